// File: doc/BRIEF.md
# Dual-Channel Elastic Sample Buffer

This block moves converter sample pairs (an I word and a Q word, 16 bits each in two's complement) from the deframer clock into the converter data clock. The writer offers a pair with `wr_valid`. `wr_ready` is the only back-pressure, and a pair moves only in a cycle where both are high. The source does not stall. A pair offered while `wr_ready` is low is lost. If the buffer was full, that loss is recorded in a sticky overflow flag. The read side has no handshake. On every converter-clock edge it puts out one pair, with `rd_valid` set for real data. When no real data is available it puts out the mid-scale code instead.

The two sides share an 8-entry, two-lane store. The pointers cross between the domains as Gray code through two-flop synchronizers. When the link layer raises `sync_req`, the write position freezes, the read side parks its position at the frozen write position, and everything not yet read is dropped. Both outputs then show mid-scale. Lowering `sync_req` alone does not reopen the buffer. Only a pulse on `align_done` (the end of the lane alignment sequence) does that. After reopening, the read side waits until half the store is filled before it starts to stream, which re-centers the buffer. A one-cycle `sw_reset` runs the same flush and re-center sequence and also clears the overflow flag. Each flush is stretched to a minimum length, so both domains finish parking their pointers before writing resumes.

Top module: `dual_dp_fifo`

## Requirements
- R1: After reset, `wr_ready`=1, `wr_full`=0, `wr_overflow`=0, `rd_valid`=0, both read words are 16'h0000, `rd_empty`=1 and `rd_underflow`=0.
- R2: Every pair accepted on the write side (`wr_valid` and `wr_ready` high at a `wr_clk` edge) comes out exactly once, in order, with I and Q intact, flagged by `rd_valid`=1. Nothing else is flagged valid.
- R3: After reset, a `sw_reset` or a re-alignment, `rd_valid` stays 0 until at least 4 pairs (half of the 8 entries) have been accepted. With only 3 accepted it stays 0 indefinitely.
- R4: Once streaming, the read position advances on every `rd_clk` edge on which data is present. With writes and reads at equal rates, `rd_valid` stays 1 on consecutive cycles.
- R5: Within 2 `wr_clk` edges of `sync_req` going high, `wr_ready` is 0 and offered pairs are dropped and never appear at the output.
- R6: While the request is being serviced, `rd_valid`=0, both read words are 16'h0000, `rd_underflow` is cleared, and pairs not yet read when the read side saw the request are discarded.
- R7: After `sync_req` falls, the buffer stays closed (`wr_ready`=0, `rd_valid`=0) until a one-cycle `align_done` pulse. `wr_ready` returns to 1 within 2 `wr_clk` edges of that pulse.
- R8: With 8 unread entries, `wr_full`=1 and `wr_ready`=0. An offered pair is dropped and sets `wr_overflow`, which stays 1 until `sw_reset`. Stored entries are unaffected.
- R9: When streaming and no entry is unread, the read side puts out 16'h0000 with `rd_valid`=0, sets `rd_underflow` (sticky), and reports `rd_empty`=1.
- R10: A `sw_reset` pulse flushes unread data, clears `wr_overflow` and `rd_underflow`, and re-centers as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Deframer (write) clock |
| wr_rst_n | input | 1 | Active-low async reset, write domain |
| wr_valid | input | 1 | A sample pair is offered |
| wr_ready | output | 1 | Pair accepted at this edge if offered |
| wr_data_i | input | 16 | I sample, two's complement |
| wr_data_q | input | 16 | Q sample, two's complement |
| sync_req | input | 1 | Link resynchronization request (write domain) |
| align_done | input | 1 | Pulse: alignment sequence finished (write domain) |
| sw_reset | input | 1 | Pulse: flush and re-center (write domain) |
| wr_full | output | 1 | All 8 entries hold unread data |
| wr_overflow | output | 1 | Sticky: a pair was offered while full |
| rd_clk | input | 1 | Converter data (read) clock |
| rd_rst_n | input | 1 | Active-low async reset, read domain |
| rd_valid | output | 1 | Read words carry real data |
| rd_data_i | output | 16 | I sample out, 16'h0000 when not valid |
| rd_data_q | output | 16 | Q sample out, 16'h0000 when not valid |
| rd_empty | output | 1 | No unread entry visible to the read side |
| rd_underflow | output | 1 | Sticky: a read found no data while streaming |

## Verification
A read pointer that is wrong shows up on the next valid output as a pair out of order, repeated or stale, so the scoreboard catches it within one read cycle. A read side that leaves priming too early is caught by a check that exactly 3 pairs never produce output. A flush that does not park the read pointer lets discarded pairs reach the output after re-alignment, where they fail the in-order comparison. A write pointer that fails to stop when full shows up as a wrong accepted count (exactly 8 from empty) and as corrupted data when the stream is drained.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  // Lanes carried per entry (I and Q).
  localparam int unsigned DPF_LANES = 2;

  // Read-side operating mode.
  typedef enum logic {
    RD_PRIME = 1'b0,   // waiting for half-full before streaming
    RD_RUN   = 1'b1    // one entry per edge while data is present
  } rd_mode_e;

endpackage

// File: rtl/dpf_sync.sv
module dpf_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/dpf_mem.sv
module dpf_mem #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NCH   = 2,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [NCH*DW-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [NCH*DW-1:0] rdata
);

  // One storage array per lane; read is asynchronous, the read side
  // only addresses entries whose write is already visible through the
  // synchronized write pointer.
  for (genvar c = 0; c < NCH; c++) begin : g_lane
    logic [DW-1:0] arr [DEPTH];

    always_ff @(posedge wclk) begin
      if (we) arr[waddr] <= wdata[c*DW +: DW];
    end

    assign rdata[c*DW +: DW] = arr[raddr];
  end

endmodule

// File: rtl/dpf_wr_ctl.sv
module dpf_wr_ctl #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned STRETCH = 12,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PW     = AW + 1,
  localparam int unsigned CW     = $clog2(STRETCH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_req,
  input  logic          align_done,
  input  logic          sw_reset,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [PW-1:0] rptr_gray_s,
  output logic [PW-1:0] wptr_gray,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic          hold_o,
  output logic          full_o,
  output logic          overflow_o
);

  logic          hold_lvl;
  logic          hold_q;
  logic [CW-1:0] hold_cnt;
  logic [PW-1:0] wptr, wptr_nxt, rptr_s_bin, level;
  logic          full;

  // Gray to binary for the synchronized read pointer.
  always_comb begin
    rptr_s_bin[PW-1] = rptr_gray_s[PW-1];
    for (int k = PW - 2; k >= 0; k--) rptr_s_bin[k] = rptr_s_bin[k+1] ^ rptr_gray_s[k];
  end

  assign level    = wptr - rptr_s_bin;
  assign full     = (level == PW'(DEPTH));
  assign wr_ready = !hold_q && !full;
  assign we       = wr_valid && wr_ready;
  assign wptr_nxt = we ? wptr + 1'b1 : wptr;
  assign waddr    = wptr[AW-1:0];
  assign hold_o   = hold_q;
  assign full_o   = full && !hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_lvl   <= 1'b0;
      hold_cnt   <= '0;
      hold_q     <= 1'b0;
      wptr       <= '0;
      wptr_gray  <= '0;
      overflow_o <= 1'b0;
    end else begin
      // Request level: set by sync_req, released only by align_done.
      if (sync_req)        hold_lvl <= 1'b1;
      else if (align_done) hold_lvl <= 1'b0;
      // Minimum flush length so the read side can park and report back.
      if (sync_req || sw_reset)  hold_cnt <= CW'(STRETCH);
      else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
      hold_q <= hold_lvl || (hold_cnt != '0);

      wptr      <= wptr_nxt;
      wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);

      if (sw_reset)                          overflow_o <= 1'b0;
      else if (wr_valid && !hold_q && full)  overflow_o <= 1'b1;
    end
  end

  AST_FROZEN_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> wptr == $past(wptr)); // R5
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |-> level <= PW'(DEPTH)); // R8
  AST_FULL_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !hold_q) |=> wptr == $past(wptr)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !sw_reset) |=> overflow_o); // R8

endmodule

// File: rtl/dpf_rd_ctl.sv
module dpf_rd_ctl
  import dpf_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NCH   = 2,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1,
  localparam int unsigned HALF = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_s,
  input  logic [PW-1:0]     wptr_gray_s,
  output logic [PW-1:0]     rptr_gray,
  output logic [AW-1:0]     raddr,
  input  logic [NCH*DW-1:0] rdata,
  output logic [NCH*DW-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty_o,
  output logic              underflow_o
);

  rd_mode_e      mode;
  logic [PW-1:0] rptr, rptr_inc, wbin_s, fill;

  always_comb begin
    wbin_s[PW-1] = wptr_gray_s[PW-1];
    for (int k = PW - 2; k >= 0; k--) wbin_s[k] = wbin_s[k+1] ^ wptr_gray_s[k];
  end

  assign fill     = wbin_s - rptr;
  assign empty_o  = (fill == '0);
  assign rptr_inc = rptr + 1'b1;
  assign raddr    = rptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= RD_PRIME;
      rptr        <= '0;
      rptr_gray   <= '0;
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      underflow_o <= 1'b0;
    end else if (hold_s) begin
      // Flush: park at the frozen write position, drop unread entries.
      mode        <= RD_PRIME;
      rptr        <= wbin_s;
      rptr_gray   <= wptr_gray_s;
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      unique case (mode)
        RD_PRIME: begin
          rd_data  <= '0;
          rd_valid <= 1'b0;
          if (fill >= PW'(HALF)) mode <= RD_RUN;
        end
        RD_RUN: begin
          if (!empty_o) begin
            rd_data   <= rdata;
            rd_valid  <= 1'b1;
            rptr      <= rptr_inc;
            rptr_gray <= rptr_inc ^ (rptr_inc >> 1);
          end else begin
            rd_data     <= '0;
            rd_valid    <= 1'b0;
            underflow_o <= 1'b1;
          end
        end
        default: mode <= RD_PRIME;
      endcase
    end
  end

  AST_MIDSCALE_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_s |=> (!rd_valid && rd_data == '0)); // R6
  AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RD_RUN && !hold_s && !empty_o) |=> rptr == $past(rptr_inc)); // R4
  AST_NO_READ_PAST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= PW'(DEPTH)); // R2
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_o && !hold_s) |=> underflow_o); // R9
  AST_PRIME_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RD_PRIME) |=> !rd_valid); // R3

endmodule

// File: rtl/dual_dp_fifo.sv
module dual_dp_fifo #(
  parameter int unsigned DW      = 16,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned STRETCH = 12
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] wr_data_q,
  input  logic          sync_req,
  input  logic          align_done,
  input  logic          sw_reset,
  output logic          wr_full,
  output logic          wr_overflow,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] rd_data_q,
  output logic          rd_empty,
  output logic          rd_underflow
);

  localparam int unsigned NCH = dpf_pkg::DPF_LANES;
  localparam int unsigned AW  = $clog2(DEPTH);
  localparam int unsigned PW  = AW + 1;

  logic [PW-1:0]     wptr_gray, wptr_gray_s, rptr_gray, rptr_gray_s;
  logic [AW-1:0]     waddr, raddr;
  logic              we, hold_w, hold_s;
  logic [NCH*DW-1:0] wdata, rdata, rd_data;

  assign wdata     = {wr_data_q, wr_data_i};
  assign rd_data_i = rd_data[DW-1:0];
  assign rd_data_q = rd_data[NCH*DW-1:DW];

  dpf_wr_ctl #(.DEPTH(DEPTH), .STRETCH(STRETCH)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .sync_req(sync_req), .align_done(align_done),
    .sw_reset(sw_reset), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rptr_gray_s(rptr_gray_s), .wptr_gray(wptr_gray), .waddr(waddr), .we(we),
    .hold_o(hold_w), .full_o(wr_full), .overflow_o(wr_overflow)
  );

  dpf_mem #(.DW(DW), .DEPTH(DEPTH), .NCH(NCH)) u_mem (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata)
  );

  dpf_sync #(.W(PW)) u_sync_wptr (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wptr_gray), .q(wptr_gray_s)
  );

  dpf_sync #(.W(1)) u_sync_hold (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(hold_w), .q(hold_s)
  );

  dpf_sync #(.W(PW)) u_sync_rptr (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rptr_gray), .q(rptr_gray_s)
  );

  dpf_rd_ctl #(.DW(DW), .DEPTH(DEPTH), .NCH(NCH)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .hold_s(hold_s), .wptr_gray_s(wptr_gray_s),
    .rptr_gray(rptr_gray), .raddr(raddr), .rdata(rdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .empty_o(rd_empty), .underflow_o(rd_underflow)
  );

endmodule

// File: tb/dual_dp_fifo_tb.sv
`timescale 1ns/1ps
module dual_dp_fifo_tb;

  logic        wr_clk = 1'b0, rd_clk = 1'b0, rd_run = 1'b1;
  logic        wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic        wr_valid = 1'b0, sync_req = 1'b0, align_done = 1'b0, sw_reset = 1'b0;
  logic [15:0] wr_data_i = '0, wr_data_q = '0;
  logic        wr_ready, wr_full, wr_overflow, rd_valid, rd_empty, rd_underflow;
  logic [15:0] rd_data_i, rd_data_q;

  int          n_chk = 0, n_bad = 0, seq = 0, acc_total = 0;
  bit          done = 1'b0;
  logic [31:0] sb_q [$];

  dual_dp_fifo u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data_i(wr_data_i), .wr_data_q(wr_data_q), .sync_req(sync_req),
    .align_done(align_done), .sw_reset(sw_reset), .wr_full(wr_full),
    .wr_overflow(wr_overflow), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .rd_valid(rd_valid), .rd_data_i(rd_data_i), .rd_data_q(rd_data_q),
    .rd_empty(rd_empty), .rd_underflow(rd_underflow)
  );

  // 250 MHz on both sides; read clock offset by 1 ns and can be paused.
  always #2 wr_clk = ~wr_clk;
  initial begin
    #1;
    forever #2 rd_clk = rd_run ? ~rd_clk : 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: offers pairs one per cycle, pushes accepted ones to the scoreboard.
  task automatic put_burst(input int n, input bit extreme, output int acc, output int rej);
    acc = 0; rej = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge wr_clk);
      wr_valid = 1'b1;
      if (extreme) begin
        wr_data_i = (k % 2 == 0) ? 16'h8000 : 16'h7FFF;
        wr_data_q = 16'(16'hFFFF - k);
      end else begin
        wr_data_i = 16'(seq * 257 + 7);
        wr_data_q = 16'(16'hA000 ^ (seq * 13));
      end
      seq++;
      #1;
      if (wr_ready) begin
        sb_q.push_back({wr_data_q, wr_data_i});
        acc++; acc_total++;
      end else rej++;
      @(posedge wr_clk);
    end
    @(negedge wr_clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_wr(input int n);
    repeat (n) @(negedge wr_clk);
  endtask

  // Monitor: compares every valid output against the scoreboard (R2) and
  // checks mid-scale whenever output is not valid (R6, R9).
  always @(negedge rd_clk) begin
    if (rd_rst_n && !done) begin
      if (rd_valid) begin
        if (sb_q.size() == 0)
          chk(1'b0, "R2", "valid pair with nothing expected", {rd_data_q, rd_data_i}, 32'h0);
        else begin
          logic [31:0] exp;
          exp = sb_q.pop_front();
          chk({rd_data_q, rd_data_i} == exp, "R2", "pair order/content", {rd_data_q, rd_data_i}, exp);
        end
      end else begin
        chk({rd_data_q, rd_data_i} == 32'h0, "R6", "mid-scale when not valid",
            {rd_data_q, rd_data_i}, 32'h0);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int a, r;
    wait_wr(5);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    wait_wr(2); #1;
    // R1 reset state
    chk(wr_ready == 1'b1, "R1", "wr_ready after reset", 32'(wr_ready), 1);
    chk(wr_full == 1'b0 && wr_overflow == 1'b0, "R1", "write flags after reset", {wr_full, wr_overflow}, 0);
    chk(rd_valid == 1'b0 && rd_data_i == 16'h0 && rd_data_q == 16'h0, "R1", "read outputs after reset",
        {rd_data_q, rd_data_i}, 0);
    chk(rd_empty == 1'b1 && rd_underflow == 1'b0, "R1", "read flags after reset", {rd_empty, rd_underflow}, 32'h2);

    // R3 priming: three pairs are not enough
    put_burst(3, 1'b0, a, r);
    wait_wr(20); #1;
    chk(rd_valid == 1'b0, "R3", "no output with 3 pairs", 32'(rd_valid), 0);
    chk(rd_empty == 1'b0, "R3", "data present while priming", 32'(rd_empty), 0);

    // R3/R4 start at half full, then continuous streaming
    fork
      put_burst(30, 1'b0, a, r);
      begin
        while (!rd_valid) @(negedge rd_clk);
        chk(acc_total >= 4, "R3", "accepted pairs at first output", 32'(acc_total), 4);
        repeat (10) begin
          @(negedge rd_clk);
          chk(rd_valid == 1'b1, "R4", "continuous output", 32'(rd_valid), 1);
        end
      end
    join
    wait_wr(30); #1;
    // R9 drained: underflow
    chk(rd_valid == 1'b0 && rd_empty == 1'b1, "R9", "empty after drain", {rd_valid, rd_empty}, 1);
    chk(rd_underflow == 1'b1, "R9", "underflow sticky", 32'(rd_underflow), 1);
    chk(sb_q.size() == 0, "R9", "all pairs delivered", 32'(sb_q.size()), 0);

    // R8 overflow with read clock paused
    rd_run = 1'b0;
    wait_wr(3);
    put_burst(12, 1'b0, a, r);
    #1;
    chk(a == 8, "R8", "accepted before full", 32'(a), 8);
    chk(wr_full == 1'b1 && wr_ready == 1'b0, "R8", "full blocks writes", {wr_full, wr_ready}, 32'h2);
    chk(wr_overflow == 1'b1, "R8", "overflow set", 32'(wr_overflow), 1);
    rd_run = 1'b1;
    wait_wr(40); #1;
    chk(sb_q.size() == 0, "R8", "stored entries intact", 32'(sb_q.size()), 0);
    chk(wr_overflow == 1'b1 && wr_full == 1'b0, "R8", "overflow sticky after drain", {wr_overflow, wr_full}, 32'h2);

    // R5/R6/R7 resync with unread data inside
    rd_run = 1'b0;
    wait_wr(3);
    put_burst(6, 1'b0, a, r);
    sync_req = 1'b1;
    wait_wr(3); #1;
    chk(wr_ready == 1'b0, "R5", "ready low during request", 32'(wr_ready), 0);
    put_burst(2, 1'b0, a, r);
    chk(r == 2, "R5", "writes dropped during request", 32'(r), 2);
    rd_run = 1'b1;
    wait_wr(20); #1;
    chk(rd_valid == 1'b0 && rd_data_i == 16'h0 && rd_data_q == 16'h0, "R6", "mid-scale during request",
        {rd_data_q, rd_data_i}, 0);
    chk(rd_underflow == 1'b0, "R6", "underflow cleared by flush", 32'(rd_underflow), 0);
    sb_q.delete();   // unread pairs are discarded by the flush
    sync_req = 1'b0;
    wait_wr(20); #1;
    chk(wr_ready == 1'b0 && rd_valid == 1'b0, "R7", "closed until align_done", {wr_ready, rd_valid}, 0);
    @(negedge wr_clk) align_done = 1'b1;
    @(negedge wr_clk) align_done = 1'b0;
    wait_wr(1); #1;
    chk(wr_ready == 1'b1, "R7", "reopened after align_done", 32'(wr_ready), 1);
    put_burst(3, 1'b1, a, r);
    wait_wr(20); #1;
    chk(rd_valid == 1'b0, "R3", "re-center after alignment", 32'(rd_valid), 0);
    put_burst(10, 1'b1, a, r);
    wait_wr(40); #1;
    chk(sb_q.size() == 0, "R2", "extreme values delivered", 32'(sb_q.size()), 0);

    // R10 software reset while full with overflow set
    rd_run = 1'b0;
    wait_wr(3);
    put_burst(10, 1'b0, a, r);
    #1;
    chk(wr_overflow == 1'b1, "R10", "overflow set before reset", 32'(wr_overflow), 1);
    @(negedge wr_clk) begin sw_reset = 1'b1; rd_run = 1'b1; end
    @(negedge wr_clk) sw_reset = 1'b0;
    wait_wr(30); #1;
    chk(wr_overflow == 1'b0 && rd_underflow == 1'b0, "R10", "flags cleared", {wr_overflow, rd_underflow}, 0);
    chk(rd_valid == 1'b0, "R10", "flushed output", 32'(rd_valid), 0);
    sb_q.delete();
    put_burst(3, 1'b0, a, r);
    wait_wr(20); #1;
    chk(rd_valid == 1'b0, "R10", "re-primed after reset", 32'(rd_valid), 0);
    put_burst(8, 1'b0, a, r);
    wait_wr(40); #1;
    chk(sb_q.size() == 0, "R10", "stream after reset delivered", 32'(sb_q.size()), 0);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule